// File: doc/BRIEF.md
# Host I/O Window Decoder with System Control Flags

This block sits between the 8-bit I/O bus of a host computer and two targets on an accelerator card: a byte-wide serial-link adapter and a small bank of system-control flags. It watches the host address and answers in a 12-byte window. The low 8 bytes of the window reach the link adapter, and the top 4 bytes reach the flag bank. Two strap inputs choose the upper part of the window base. One strap setting ignores the upper address bits, so the window then repeats in every 256-byte page.

Each of the two regions has its own strap input, active low, that shows whether its cable plug is fitted. A region with no plug never answers. For the adapter, the block builds the chip-select and direction signals from the host strobes. A write is delayed until the write strobe has been seen by one host-clock sample. The flag bank holds reset, analyse and interrupt-enable bits. It returns the card's error state on reads and raises an interrupt when an error is present and interrupts are enabled.

Top module: `hostio_decode`

## Requirements
- R1: The window matches when address bits 9:8 equal `base_sel`, giving bases 0x0D0, 0x1D0 and 0x2D0 for settings 0, 1 and 2. When `base_sel` is 3, bits 9:8 are ignored, so the window also answers at 0x3D0.
- R2: Window offsets 0x0 to 0x7 select the adapter and offsets 0x8 to 0xB select the flag bank. Only address bits 7:2 are decoded. Nothing is selected while `bus_en` is low.
- R3: The adapter region answers only while `link_jmp_n` is low. The flag region answers only while `sys_jmp_n` is low. Otherwise writes leave the flags unchanged.
- R4: A host write to the flag region updates one flag from `wr_bit` (1 sets it, 0 clears it) at the next `clk` rising edge. Index `addr[1:0]`=0 is reset (`sub_reset`), 1 is analyse (`sub_analyse`) and 2 is interrupt-enable. Index 3 changes nothing.
- R5: While the flag region is selected and `ior_n` is low, `sys_rd_bit` equals the inverse of `err_n`. At all other times it is 0.
- R6: `err_irq` is high exactly when `err_n` is low and the interrupt-enable flag is 1.
- R7: `lnk_cs_n` goes low at once for an adapter read. For an adapter write it goes low only when `iow_n` is low and was also low at the previous `clk` rising edge.
- R8: `lnk_wr` is 1 while the adapter is selected and `iow_n` was low at the previous `clk` rising edge. Otherwise it is 0.
- R9: `lnk_rs` equals `addr[2:1]`, which picks one of the adapter's four registers.
- R10: A synchronous reset on `rst` clears all three flags and treats the write strobe as inactive from the last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 10 | Host I/O address |
| bus_en | input | 1 | Bus-cycle qualifier, active high |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| wr_bit | input | 1 | Host write data bit 0 |
| base_sel | input | 2 | Window base strap |
| link_jmp_n | input | 1 | Adapter plug fitted, active low |
| sys_jmp_n | input | 1 | Flag-bank plug fitted, active low |
| err_n | input | 1 | Card error, active low |
| lnk_cs_n | output | 1 | Adapter chip-select, active low |
| lnk_wr | output | 1 | Adapter direction, 1 means write |
| lnk_rs | output | 2 | Adapter register select |
| sys_rd_bit | output | 1 | Read data bit 0 from the flag region |
| sub_reset | output | 1 | Reset flag |
| sub_analyse | output | 1 | Analyse flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The random stimulus puts most addresses inside or near one of the four 0x?D0 pages. It varies all four strap settings, both plug inputs and the bus qualifier. This shows whether a near-miss offset, a wrong page or a missing plug is told apart from a real hit. Strobe patterns mix single-cycle and multi-cycle writes with reads. This shows whether the one-sample write delay and the immediate read select have been swapped. Directed runs cover the mirrored 0x3D0 window, the unused fourth flag index, and enabling interrupts with the error input both high and low.

// File: rtl/hio_pkg.sv
package hio_pkg;

    typedef enum logic [1:0] {
        FLAG_RESET   = 2'd0,
        FLAG_ANALYSE = 2'd1,
        FLAG_IRQ_EN  = 2'd2,
        FLAG_NONE    = 2'd3
    } flag_idx_e;

    typedef struct packed {
        logic link;
        logic sys;
    } region_sel_t;

    typedef struct packed {
        logic rst_f;
        logic ana_f;
        logic ie_f;
    } flag_bank_t;

    function automatic logic page_match(input logic [1:0] hi_bits,
                                        input logic [1:0] strap);
        return (&strap) || (hi_bits == strap);
    endfunction

endpackage

// File: rtl/hio_addr_dec.sv
module hio_addr_dec
    import hio_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WIN_BASE   = 'hD0,
    parameter int LINK_BYTES = 8,
    parameter int SYS_BYTES  = 4
) (
    input  logic [ADDR_W-1:2] addr_hi,
    input  logic              bus_en,
    input  logic [1:0]        base_sel,
    input  logic              link_jmp_n,
    input  logic              sys_jmp_n,
    output region_sel_t       sel
);
    localparam int          LINK_WORDS = LINK_BYTES / 4;
    localparam int          SYS_WORDS  = SYS_BYTES / 4;
    localparam logic [5:0]  WIN_WORD   = 6'(WIN_BASE >> 2);

    logic       hit_page;
    logic [5:0] word_ofs;

    always_comb begin
        hit_page = bus_en && page_match(addr_hi[ADDR_W-1:ADDR_W-2], base_sel);
        word_ofs = addr_hi[7:2] - WIN_WORD;
        sel.link = hit_page && !link_jmp_n && (int'(word_ofs) < LINK_WORDS);
        sel.sys  = hit_page && !sys_jmp_n &&
                   (int'(word_ofs) >= LINK_WORDS) &&
                   (int'(word_ofs) < LINK_WORDS + SYS_WORDS);
    end

endmodule

// File: rtl/hio_link_timing.sv
module hio_link_timing (
    input  logic clk,
    input  logic rst,
    input  logic link_sel,
    input  logic ior_n,
    input  logic iow_n,
    output logic lnk_cs_n,
    output logic lnk_wr
);
    logic iow_smp_n;
    logic wr_go;

    always_ff @(posedge clk) begin
        if (rst) iow_smp_n <= 1'b1;
        else     iow_smp_n <= iow_n;
    end

    always_comb begin
        wr_go    = !iow_n && !iow_smp_n;
        lnk_cs_n = !(link_sel && (!ior_n || wr_go));
        lnk_wr   = link_sel && (wr_go || !iow_smp_n);
    end

endmodule

// File: rtl/hio_sys_regs.sv
module hio_sys_regs
    import hio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_sel,
    input  logic       ior_n,
    input  logic       iow_n,
    input  logic [1:0] idx,
    input  logic       wr_bit,
    input  logic       err_n,
    output flag_bank_t flags,
    output logic       rd_bit,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (sys_sel && !iow_n) begin
            unique case (flag_idx_e'(idx))
                FLAG_RESET:   flags.rst_f <= wr_bit;
                FLAG_ANALYSE: flags.ana_f <= wr_bit;
                FLAG_IRQ_EN:  flags.ie_f  <= wr_bit;
                FLAG_NONE:    ;
            endcase
        end
    end

    always_comb begin
        rd_bit = sys_sel && !ior_n && !err_n;
        irq    = !err_n && flags.ie_f;
    end

endmodule

// File: rtl/hostio_decode.sv
module hostio_decode
    import hio_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WIN_BASE   = 'hD0,
    parameter int LINK_BYTES = 8,
    parameter int SYS_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_en,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              wr_bit,
    input  logic [1:0]        base_sel,
    input  logic              link_jmp_n,
    input  logic              sys_jmp_n,
    input  logic              err_n,
    output logic              lnk_cs_n,
    output logic              lnk_wr,
    output logic [1:0]        lnk_rs,
    output logic              sys_rd_bit,
    output logic              sub_reset,
    output logic              sub_analyse,
    output logic              err_irq
);
    region_sel_t sel;
    flag_bank_t  flags;
    logic        link_sel;
    logic        sys_sel;

    hio_addr_dec #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
        .LINK_BYTES(LINK_BYTES), .SYS_BYTES(SYS_BYTES)
    ) u_dec (
        .addr_hi(addr[ADDR_W-1:2]), .bus_en(bus_en), .base_sel(base_sel),
        .link_jmp_n(link_jmp_n), .sys_jmp_n(sys_jmp_n), .sel(sel)
    );

    assign link_sel = sel.link;
    assign sys_sel  = sel.sys;
    assign lnk_rs   = addr[2:1];

    hio_link_timing u_tim (
        .clk(clk), .rst(rst), .link_sel(link_sel), .ior_n(ior_n),
        .iow_n(iow_n), .lnk_cs_n(lnk_cs_n), .lnk_wr(lnk_wr)
    );

    hio_sys_regs u_regs (
        .clk(clk), .rst(rst), .sys_sel(sys_sel), .ior_n(ior_n),
        .iow_n(iow_n), .idx(addr[1:0]), .wr_bit(wr_bit), .err_n(err_n),
        .flags(flags), .rd_bit(sys_rd_bit), .irq(err_irq)
    );

    assign sub_reset   = flags.rst_f;
    assign sub_analyse = flags.ana_f;

endmodule

// File: rtl/hio_checks.sv
module hio_checks (
    input logic       clk,
    input logic       rst,
    input logic       ior_n,
    input logic       iow_n,
    input logic       link_jmp_n,
    input logic       sys_jmp_n,
    input logic       err_n,
    input logic       link_sel,
    input logic       sys_sel,
    input logic [1:0] sys_idx,
    input logic       wr_bit,
    input logic       lnk_cs_n,
    input logic       lnk_wr,
    input logic       sub_reset,
    input logic       err_irq
);
    p_link_plug_r3: assert property (@(posedge clk) disable iff (rst)
        link_jmp_n |-> (lnk_cs_n && !lnk_wr));

    p_sys_plug_r3: assert property (@(posedge clk) disable iff (rst)
        (sys_jmp_n && !iow_n) |=> $stable(sub_reset));

    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (sys_sel && !iow_n && sys_idx == 2'd0) |=> (sub_reset == $past(wr_bit)));

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        err_n |-> !err_irq);

    p_read_cs_r7: assert property (@(posedge clk) disable iff (rst)
        (link_sel && !ior_n) |-> !lnk_cs_n);

    p_write_delay_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(iow_n) && ior_n) |-> lnk_cs_n);
endmodule

bind hostio_decode hio_checks u_chk (
    .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n),
    .link_jmp_n(link_jmp_n), .sys_jmp_n(sys_jmp_n), .err_n(err_n),
    .link_sel(link_sel), .sys_sel(sys_sel), .sys_idx(addr[1:0]),
    .wr_bit(wr_bit), .lnk_cs_n(lnk_cs_n), .lnk_wr(lnk_wr),
    .sub_reset(sub_reset), .err_irq(err_irq)
);

// File: tb/tb_hostio_decode.sv
module tb_hostio_decode;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] addr;
    logic       bus_en, ior_n, iow_n, wr_bit;
    logic [1:0] base_sel;
    logic       link_jmp_n, sys_jmp_n, err_n;
    logic       lnk_cs_n, lnk_wr, sys_rd_bit, sub_reset, sub_analyse, err_irq;
    logic [1:0] lnk_rs;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // bench reference state, built from the requirements
    logic m_iowq, m_rst, m_ana, m_ie;

    always #2 clk = ~clk;

    hostio_decode dut (
        .clk(clk), .rst(rst), .addr(addr), .bus_en(bus_en), .ior_n(ior_n),
        .iow_n(iow_n), .wr_bit(wr_bit), .base_sel(base_sel),
        .link_jmp_n(link_jmp_n), .sys_jmp_n(sys_jmp_n), .err_n(err_n),
        .lnk_cs_n(lnk_cs_n), .lnk_wr(lnk_wr), .lnk_rs(lnk_rs),
        .sys_rd_bit(sys_rd_bit), .sub_reset(sub_reset),
        .sub_analyse(sub_analyse), .err_irq(err_irq)
    );

    function automatic bit e_hit();
        return bus_en && (base_sel == 2'd3 || addr[9:8] == base_sel);
    endfunction
    function automatic bit e_link();
        return e_hit() && !link_jmp_n && addr[7:3] == 5'b11010;
    endfunction
    function automatic bit e_sys();
        return e_hit() && !sys_jmp_n && addr[7:2] == 6'b110110;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_iowq <= 1'b1; m_rst <= 1'b0; m_ana <= 1'b0; m_ie <= 1'b0;
        end else begin
            m_iowq <= iow_n;
            if (e_sys() && !iow_n) begin
                case (addr[1:0])
                    2'd0: m_rst <= wr_bit;
                    2'd1: m_ana <= wr_bit;
                    2'd2: m_ie  <= wr_bit;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h act=%0d exp=%0d", tag, addr, act, exp);
        end
    endtask

    task automatic check_all();
        bit lk = e_link();
        bit sy = e_sys();
        chk("R1/R2/R3/R7 cs", {1'b0, lnk_cs_n},
            {1'b0, !(lk && (!ior_n || (!iow_n && !m_iowq)))});
        chk("R8 wr", {1'b0, lnk_wr}, {1'b0, lk && !m_iowq});
        chk("R9 rs", lnk_rs, addr[2:1]);
        chk("R5 rd", {1'b0, sys_rd_bit}, {1'b0, sy && !ior_n && !err_n});
        chk("R4/R10 flags", {sub_reset, sub_analyse}, {m_rst, m_ana});
        chk("R6 irq", {1'b0, err_irq}, {1'b0, !err_n && m_ie});
    endtask

    task automatic step(input logic [9:0] a, input logic rd_n, input logic w_n,
                        input logic d);
        @(negedge clk);
        addr = a; ior_n = rd_n; iow_n = w_n; wr_bit = d;
        #1 check_all();
    endtask

    initial begin
        #(200000 * 4);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; addr = 0; bus_en = 1; ior_n = 1; iow_n = 1; wr_bit = 0;
        base_sel = 0; link_jmp_n = 0; sys_jmp_n = 0; err_n = 1;
        repeat (3) @(negedge clk);
        #1 check_all();   // R10 reset state
        @(negedge clk); rst = 0;

        // R4: write each flag, including unused index 3
        step(10'h0D8, 1, 0, 1); step(10'h0D9, 1, 0, 1); step(10'h0DB, 1, 0, 1);
        step(10'h0DA, 1, 0, 1); step(10'h000, 1, 1, 0);
        // R6: error with enable set, then cleared
        err_n = 0; step(10'h0DA, 0, 1, 0);   // R5 read of error
        step(10'h0DA, 1, 0, 0); step(10'h000, 1, 1, 0);
        err_n = 1;
        // R7/R8: multi-cycle adapter write, then read
        step(10'h0D2, 1, 0, 0); step(10'h0D2, 1, 0, 0); step(10'h0D2, 1, 0, 0);
        step(10'h0D4, 1, 1, 0); step(10'h0D6, 0, 1, 0); step(10'h000, 1, 1, 0);
        // R1: mirrored page with strap 3, and wrong page with strap 2
        base_sel = 2'd3; step(10'h3D0, 0, 1, 0); step(10'h1D8, 1, 0, 1);
        base_sel = 2'd2; step(10'h1D0, 0, 1, 0); step(10'h2D0, 0, 1, 0);
        // R3: plugs removed
        link_jmp_n = 1; sys_jmp_n = 1;
        step(10'h2D0, 0, 0, 0); step(10'h2D8, 1, 0, 0); step(10'h000, 1, 1, 0);
        // R2: bus qualifier low
        link_jmp_n = 0; sys_jmp_n = 0; bus_en = 0;
        step(10'h2D0, 0, 1, 0); step(10'h2D9, 1, 0, 0);
        bus_en = 1;

        for (int i = 0; i < 600; i++) begin
            logic [9:0] a;
            a = {2'($urandom), 8'hCC + 8'($urandom % 20)};
            base_sel = 2'($urandom); bus_en = ($urandom % 10) != 0;
            link_jmp_n = ($urandom % 6) == 0; sys_jmp_n = ($urandom % 6) == 0;
            err_n = 1'($urandom);
            step(a, ($urandom % 3) != 0, ($urandom % 2) != 0, 1'($urandom));
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule